// File: doc/BRIEF.md
# Shadow Observation Chain with Signature Compaction

This block is a row of observation cells placed beside the state flip-flops of a logic block. Each cell watches one internal state bit, delivered to it on a parallel bus. The cells only read that bus and have no path back into the flops they watch, so taking a snapshot never changes the monitored logic. Two controls, `sample` and `shift`, set what the cells do on each clock edge. Three modes come from them: a parallel capture of the watched bits, a serial shift from `scan_in` toward `scan_out`, and a signature mode. In signature mode every cell takes the XOR of its upstream neighbour and its watched bit on every cycle.

Snapshot mode is cheap, but the chain must be shifted out completely before the next capture is taken. A chain of N cells therefore sees at most one cycle in every N. Signature mode folds the watched bits into the chain contents on every cycle instead. Unloading the chain afterwards gives a compact fingerprint of a whole run. A synchronous reset clears every cell, so each signature run starts from all zeros.

Top module: `obs_chain`

## Requirements
- R1: A cycle with `rst` high clears every cell to 0, so `scan_out` reads 0 afterwards and an unload returns all zeros.
- R2: With `sample`=1 and `shift`=0, cell i loads `obs_data[i]` on the clock edge, for every i at once.
- R3: With `sample`=0 and `shift`=1, cell 0 loads `scan_in` and cell i loads the old value of cell i-1 on the clock edge.
- R4: With `sample`=1 and `shift`=1, cell 0 loads `scan_in ^ obs_data[0]` and cell i loads the old value of cell i-1 XOR `obs_data[i]` on the clock edge.
- R5: With `sample`=0 and `shift`=0, every cell keeps its value.
- R6: `scan_out` always shows the last cell (index CHAIN_LEN-1). After a capture of value D, `scan_out` shows D[CHAIN_LEN-1-k] after k shift cycles, so a full unload takes CHAIN_LEN shift cycles and comes out highest index first.
- R7: After K cycles of signature mode starting from reset, the chain holds the value that a reference model computes from the same `obs_data` and `scan_in` sequence using the R4 rule.
- R8: `rst` takes priority over `sample` and `shift`; a reset cycle with both controls high still leaves all cells at 0.
- R9: `obs_data` has no effect on the cells in hold and shift-only cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| obs_data | input | CHAIN_LEN | Watched state bits, bit i feeds cell i |
| sample | input | 1 | Parallel-load control |
| shift | input | 1 | Serial-move control |
| scan_in | input | 1 | Serial input into cell 0 |
| scan_out | output | 1 | Serial output from the last cell |

## Verification
The only window into the cells is one serial pin, so the chain contents cannot be read without changing them. The bench gets to every state check through an unload of CHAIN_LEN shift cycles. During each unload it changes `obs_data` on every cycle, which also shows that shift-only cycles ignore the bus. For the signature run, the bench starts from reset and drives many cycles of pseudo-random watched data and serial input. It updates its own model at the same time, then unloads the chain and compares the result with the model.

// File: rtl/obs_chain_pkg.sv
package obs_chain_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD      = 2'b00,
        MODE_SHIFT     = 2'b01,
        MODE_CAPTURE   = 2'b10,
        MODE_SIGNATURE = 2'b11
    } chain_mode_e;

    typedef struct packed {
        logic val;
    } cell_state_t;

endpackage

// File: rtl/obs_mode_dec.sv
module obs_mode_dec
    import obs_chain_pkg::*;
(
    input  logic        sample,
    input  logic        shift,
    output chain_mode_e mode
);

    always_comb begin
        unique case ({sample, shift})
            2'b00:   mode = MODE_HOLD;
            2'b01:   mode = MODE_SHIFT;
            2'b10:   mode = MODE_CAPTURE;
            default: mode = MODE_SIGNATURE;
        endcase
    end

endmodule

// File: rtl/obs_cell.sv
module obs_cell
    import obs_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chain_mode_e mode,
    input  logic        chain_in,
    input  logic        watch_bit,
    output logic        cell_out
);

    cell_state_t cell_d;
    cell_state_t cell_q;

    always_comb begin
        cell_d = cell_q;
        if (rst) begin
            cell_d.val = 1'b0;
        end else begin
            unique case (mode)
                MODE_HOLD:      cell_d.val = cell_q.val;
                MODE_SHIFT:     cell_d.val = chain_in;
                MODE_CAPTURE:   cell_d.val = watch_bit;
                MODE_SIGNATURE: cell_d.val = chain_in ^ watch_bit;
                default:        cell_d.val = cell_q.val;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        cell_q <= cell_d;
    end

    assign cell_out = cell_q.val;

endmodule

// File: rtl/obs_chain.sv
module obs_chain
    import obs_chain_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CHAIN_LEN-1:0] obs_data,
    input  logic                 sample,
    input  logic                 shift,
    input  logic                 scan_in,
    output logic                 scan_out
);

    localparam int LAST = CHAIN_LEN - 1;

    chain_mode_e          mode;
    logic [CHAIN_LEN-1:0] cells_q;
    logic [CHAIN_LEN-1:0] link_d;

    obs_mode_dec u_dec (
        .sample (sample),
        .shift  (shift),
        .mode   (mode)
    );

    generate
        for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
            if (i == 0) begin : g_head
                assign link_d[i] = scan_in;
            end else begin : g_body
                assign link_d[i] = cells_q[i-1];
            end

            obs_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .mode      (mode),
                .chain_in  (link_d[i]),
                .watch_bit (obs_data[i]),
                .cell_out  (cells_q[i])
            );
        end
    endgenerate

    assign scan_out = cells_q[LAST];

    // R1 / R8: the cycle after reset is released, every cell reads zero
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cells_q == '0));

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (sample && !shift) |=> (cells_q == $past(obs_data)));

    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        (shift && !sample) |=> (cells_q == {$past(cells_q[LAST-1:0]), $past(scan_in)}));

    a_r4_signature: assert property (@(posedge clk) disable iff (rst)
        (shift && sample) |=>
        (cells_q == ({$past(cells_q[LAST-1:0]), $past(scan_in)} ^ $past(obs_data))));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift && !sample) |=> $stable(cells_q));

endmodule

// File: tb/obs_chain_test.sv
module obs_chain_test;

    localparam int N     = 8;
    localparam int NVEC  = 12;
    localparam int SIG_K = 40;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] obs_data;
    logic         sample;
    logic         shift;
    logic         scan_in;
    logic         scan_out;

    int tests_run = 0;
    int tests_failed = 0;

    always #5 clk = ~clk;

    obs_chain #(.CHAIN_LEN(N)) uut (
        .clk      (clk),
        .rst      (rst),
        .obs_data (obs_data),
        .sample   (sample),
        .shift    (shift),
        .scan_in  (scan_in),
        .scan_out (scan_out)
    );

    // Each entry: {sample, shift, scan_in, obs_data}
    localparam logic [N+2:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 8'hA5},
        {1'b0, 1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b1, 1'b1, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h3C},
        {1'b1, 1'b1, 1'b1, 8'h0F},
        {1'b1, 1'b1, 1'b0, 8'hF0},
        {1'b0, 1'b0, 1'b0, 8'h55},
        {1'b1, 1'b0, 1'b0, 8'h81},
        {1'b0, 1'b1, 1'b1, 8'h7E},
        {1'b1, 1'b1, 1'b1, 8'h99},
        {1'b0, 1'b0, 1'b1, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h66}
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("[TB] FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Shift the whole chain out; obs_data changes every cycle (R9 in shift mode)
    task automatic unload(output logic [N-1:0] v);
        for (int k = 0; k < N; k++) begin
            sample   = 1'b0;
            shift    = 1'b1;
            scan_in  = 1'b0;
            obs_data = N'(k * 37 + 19);
            v[N-1-k] = scan_out;
            step();
        end
        shift = 1'b0;
    endtask

    function automatic logic [N-1:0] model_next(input logic [N-1:0] cur, input logic s,
                                                input logic h, input logic si,
                                                input logic [N-1:0] ob);
        logic [N-1:0] moved;
        moved = {cur[N-2:0], si};
        if (s && h)      return moved ^ ob;
        else if (h)      return moved;
        else if (s)      return ob;
        else             return cur;
    endfunction

    initial begin
        #2_000_000;
        tests_failed++;
        $display("[TB] FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        logic [N-1:0] model;
        logic [N-1:0] got;
        logic [N-1:0] lfsr;

        rst = 1'b1; sample = 1'b1; shift = 1'b1; scan_in = 1'b1; obs_data = '1;
        @(negedge clk);
        step();
        rst = 1'b0; sample = 1'b0; shift = 1'b0;
        // R8: reset cycles were taken with both controls high
        check("R8 reset beats controls", {7'b0, scan_out}, '0);
        unload(got);
        check("R1 reset clears chain", got, '0);

        // Table walk: model follows R2..R5 per entry
        model = '0;
        for (int v = 0; v < NVEC; v++) begin
            sample   = VEC[v][N+2];
            shift    = VEC[v][N+1];
            scan_in  = VEC[v][N];
            obs_data = VEC[v][N-1:0];
            model    = model_next(model, sample, shift, scan_in, obs_data);
            step();
            check("R2/R3/R4/R5 table scan_out", {7'b0, scan_out}, {7'b0, model[N-1]});
        end
        sample = 1'b0; shift = 1'b0;
        unload(got);
        check("R2/R3/R4/R5 table contents", got, model);

        // R6: capture, then bits leave highest index first
        sample = 1'b1; obs_data = 8'hC6;
        step();
        sample = 1'b0;
        for (int k = 0; k < N; k++) begin
            check("R6 unload order", {7'b0, scan_out}, {7'b0, got[0] ^ got[0] ^ (8'hC6 >> (N-1-k)) & 8'h01});
            shift = 1'b1; scan_in = 1'b1; obs_data = N'(k * 11);
            step();
        end
        shift = 1'b0;
        unload(got);
        check("R3 chain refilled from scan_in", got, '1);

        // R9 / R5: hold ignores obs_data
        sample = 1'b1; obs_data = 8'h3A;
        step();
        sample = 1'b0;
        for (int k = 0; k < 4; k++) begin
            obs_data = N'(k * 73 + 5);
            step();
        end
        unload(got);
        check("R9 hold ignores obs_data", got, 8'h3A);
        // R9 in shift mode: unload above changed obs_data each cycle, chain now zero
        unload(got);
        check("R9 shift ignores obs_data", got, '0);

        // R7: signature run from reset
        rst = 1'b1;
        step();
        rst = 1'b0;
        model = '0;
        lfsr  = 8'h1D;
        for (int k = 0; k < SIG_K; k++) begin
            sample   = 1'b1;
            shift    = 1'b1;
            obs_data = lfsr;
            scan_in  = lfsr[3] ^ lfsr[0];
            model    = model_next(model, 1'b1, 1'b1, scan_in, obs_data);
            step();
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        sample = 1'b0; shift = 1'b0;
        check("R7 signature scan_out", {7'b0, scan_out}, {7'b0, model[N-1]});
        unload(got);
        check("R7 signature contents", got, model);

        // R4 single step on known state
        sample = 1'b1; obs_data = 8'hF0;
        step();
        sample = 1'b1; shift = 1'b1; scan_in = 1'b1; obs_data = 8'h0F;
        step();
        sample = 1'b0; shift = 1'b0;
        unload(got);
        check("R4 one signature step", got, 8'hEE);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule